// File: doc/BRIEF.md
# Table-Write Engine (Data Memory to Program Memory)

This block carries out the table-write operation of a small 16-bit signal-processing core. It copies words from data memory into program memory. A one-cycle start request presents the decoded instruction word. When the opcode matches, the engine takes over the core's fetch-address register. It parks the old fetch address in a holding register and loads the accumulator into the fetch register, which then serves as the program-memory write address. It reads the data word and writes it to program memory. It repeats this once per cycle while a latched repeat count is nonzero, stepping the write address up by one after each word. It then puts the saved fetch address back and pulses done.

The data address is formed once at start and is held for the whole operation. In direct mode it is the data page joined with a 7-bit offset from the instruction. In indirect mode it is the address the caller supplies. When the processor/microcomputer mode input is low, program addresses below 4096 belong to on-chip ROM. Such a transfer raises no write request but still completes.

The program-memory write side is a valid/ready stream. A request is held with a stable address and a stable read address until `pm_wr_ready` is high, and a stalled transfer does not advance the count. Data memory is read combinationally: `dm_rd_data` answers `dm_rd_addr` in the same cycle.

Top module: `tblw_engine`

## Requirements
- R1: A start is accepted only when instruction bits 15..8 equal 8'b01011001 and the engine is idle. After acceptance, `busy` is high from the next cycle on. A start with any other opcode, or a start while busy, has no effect on any output.
- R2: On acceptance, `pfc_in` is saved, the accumulator is loaded into `fetch_addr` (visible the next cycle), and `pc_step` pulses high for exactly one cycle.
- R3: Instruction bit 7 = 0 selects direct mode, with `dm_rd_addr` = {`data_page`, instruction bits 6..0}. Bit 7 = 1 selects `ind_addr`. The data address is latched at acceptance and does not change for the rest of the operation.
- R4: In every transfer cycle `dm_rd_en` is high. When the write is allowed, `pm_wr_valid` is high with `pm_wr_addr` = `fetch_addr` and `pm_wr_data` = `dm_rd_data`.
- R5: With repeat count n, exactly n+1 transfers take place, to addresses acc, acc+1, …, acc+n (modulo 2^16). With ready held high, one transfer completes per cycle.
- R6: While `pm_wr_valid` is high and `pm_wr_ready` is low, the engine stalls: the address, `dm_rd_addr` and the transfer count do not change.
- R7: When `mp_mode` is 0 and `fetch_addr` < 4096, `pm_wr_valid` stays low. That transfer completes in one cycle regardless of `pm_wr_ready`.
- R8: One cycle after the last transfer completes, the saved fetch address is restored. In the following cycle `done` is high for one cycle, with `busy` low and `fetch_addr` equal to the saved value.
- R9: A synchronous active-high reset clears the control state, the holding register, `fetch_addr`, `done`, `pc_step` and all strobes.
- R10: The direct-mode form of the table-write with accumulator 257, data page 32, offset 5 and data word 4339 at data address 4101 leaves 4339 at program address 257. The indirect form with `ind_addr` 4101 has the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled while idle |
| instr | input | 16 | Decoded instruction word |
| acc | input | 16 | Accumulator low word, the program start address |
| rpt_cnt | input | 8 | Repeat count (transfers minus one) |
| data_page | input | 9 | Data page for direct addressing |
| ind_addr | input | 16 | Data address for indirect addressing |
| pfc_in | input | 16 | Core's fetch address, saved at start |
| mp_mode | input | 1 | High: processor mode (no on-chip ROM); low: ROM below 4096 |
| dm_rd_en | output | 1 | Data memory read strobe |
| dm_rd_addr | output | 16 | Data memory read address |
| dm_rd_data | input | 16 | Data memory read word (same cycle) |
| pm_wr_valid | output | 1 | Program memory write request |
| pm_wr_ready | input | 1 | Program memory accepts the write |
| pm_wr_addr | output | 16 | Program memory write address |
| pm_wr_data | output | 16 | Program memory write word |
| fetch_addr | output | 16 | Current fetch-address register value |
| busy | output | 1 | Engine owns the fetch register |
| pc_step | output | 1 | One-cycle pulse: program counter advances past the instruction |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check several properties on every cycle. They confirm that no write request reaches a ROM address in microcomputer mode, and that a stalled request keeps its address and read address. They check that the fetch register steps by exactly one per completed transfer, that the restore brings back the held value, and that done is a lone pulse seen only when idle. Other behaviour only the bench scenarios can show: the transfer count for a given repeat value, the words that land in program memory, direct and indirect address formation, the worked example, and the rejection of wrong opcodes and of starts while busy. The cycle-by-cycle reference model covers ready patterns with gaps, a block that straddles the ROM boundary, and a restart on the done cycle.

// File: rtl/tblw_pkg.sv
package tblw_pkg;
  localparam logic [7:0] TBLW_OPCODE = 8'b0101_1001;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RSTR = 2'd2
  } tblw_state_e;
endpackage

// File: rtl/tblw_decode.sv
module tblw_decode #(
  parameter int IW    = 16,
  parameter int DP_W  = 9,
  parameter int OFS_W = 7,
  parameter int DAW   = DP_W + OFS_W
) (
  input  logic [IW-1:0]   instr,
  input  logic [DP_W-1:0] data_page,
  input  logic [DAW-1:0]  ind_addr,
  output logic            op_hit,
  output logic [DAW-1:0]  op_daddr
);
  import tblw_pkg::*;

  localparam int OPC_LSB = IW - 8;
  localparam int IND_BIT = OPC_LSB - 1;

  logic indirect;

  always_comb begin
    op_hit   = (instr[IW-1:OPC_LSB] == TBLW_OPCODE);
    indirect = instr[IND_BIT];
    if (indirect) op_daddr = ind_addr;
    else          op_daddr = {data_page, instr[OFS_W-1:0]};
  end

  // Only a 16-bit opcode layout with an 8-bit opcode field is meaningful.
  initial begin
    layout_chk: assert (IND_BIT >= OFS_W && IND_BIT < IW);
  end
endmodule

// File: rtl/tblw_ctrl.sv
module tblw_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             op_hit,
  input  logic [CNT_W-1:0] rpt_cnt,
  input  logic             beat_ok,
  output logic             load,
  output logic             step_addr,
  output logic             restore,
  output logic             in_xfer,
  output logic             busy,
  output logic             pc_step,
  output logic             done
);
  import tblw_pkg::*;

  tblw_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_beat;

  always_comb begin
    in_xfer   = (state_q == ST_XFER);
    busy      = (state_q != ST_IDLE);
    restore   = (state_q == ST_RSTR);
    load      = (state_q == ST_IDLE) && start && op_hit;
    last_beat = (cnt_q == '0);
    step_addr = in_xfer && beat_ok && !last_beat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
      pc_step <= 1'b0;
    end else begin
      done    <= 1'b0;
      pc_step <= 1'b0;
      case (state_q)
        ST_IDLE: if (load) begin
          state_q <= ST_XFER;
          cnt_q   <= rpt_cnt;
          pc_step <= 1'b1;
        end
        ST_XFER: if (beat_ok) begin
          if (last_beat) state_q <= ST_RSTR;
          else           cnt_q   <= cnt_q - 1'b1;
        end
        ST_RSTR: begin
          state_q <= ST_IDLE;
          done    <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && op_hit && !busy) |=> busy);

  // R2
  pc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pc_step |=> !pc_step);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_xfer && !beat_ok) |=> (in_xfer && $stable(cnt_q)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(restore)));
endmodule

// File: rtl/tblw_addr.sv
module tblw_addr #(
  parameter int AW        = 16,
  parameter int DAW       = 16,
  parameter int ROM_WORDS = 4096
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step_addr,
  input  logic           restore,
  input  logic           mp_mode,
  input  logic [AW-1:0]  acc,
  input  logic [AW-1:0]  pfc_in,
  input  logic [DAW-1:0] op_daddr,
  output logic [AW-1:0]  fetch_q,
  output logic [DAW-1:0] daddr_q,
  output logic           rom_hit
);
  localparam logic [AW-1:0] ROM_TOP = AW'(ROM_WORDS);

  logic [AW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_q <= '0;
      hold_q  <= '0;
      daddr_q <= '0;
    end else if (load) begin
      hold_q  <= pfc_in;
      fetch_q <= acc;
      daddr_q <= op_daddr;
    end else if (step_addr) begin
      fetch_q <= fetch_q + 1'b1;
    end else if (restore) begin
      fetch_q <= hold_q;
    end
  end

  always_comb rom_hit = !mp_mode && (fetch_q < ROM_TOP);

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    step_addr |=> (fetch_q == $past(fetch_q) + 1'b1));

  // R8
  restore_val_chk: assert property (@(posedge clk) disable iff (rst)
    restore |=> (fetch_q == $past(hold_q)));

  // R2
  load_acc_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (fetch_q == $past(acc)));
endmodule

// File: rtl/tblw_engine.sv
module tblw_engine #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int IW        = 16,
  parameter int CNT_W     = 8,
  parameter int DP_W      = 9,
  parameter int OFS_W     = 7,
  parameter int ROM_WORDS = 4096
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [IW-1:0]          instr,
  input  logic [AW-1:0]          acc,
  input  logic [CNT_W-1:0]       rpt_cnt,
  input  logic [DP_W-1:0]        data_page,
  input  logic [DP_W+OFS_W-1:0]  ind_addr,
  input  logic [AW-1:0]          pfc_in,
  input  logic                   mp_mode,
  output logic                   dm_rd_en,
  output logic [DP_W+OFS_W-1:0]  dm_rd_addr,
  input  logic [DW-1:0]          dm_rd_data,
  output logic                   pm_wr_valid,
  input  logic                   pm_wr_ready,
  output logic [AW-1:0]          pm_wr_addr,
  output logic [DW-1:0]          pm_wr_data,
  output logic [AW-1:0]          fetch_addr,
  output logic                   busy,
  output logic                   pc_step,
  output logic                   done
);
  localparam int DAW = DP_W + OFS_W;

  logic           op_hit;
  logic [DAW-1:0] op_daddr;
  logic           load, step_addr, restore, in_xfer, rom_hit, beat_ok;
  logic [AW-1:0]  fetch_q;
  logic [DAW-1:0] daddr_q;

  tblw_decode #(.IW(IW), .DP_W(DP_W), .OFS_W(OFS_W), .DAW(DAW)) u_dec (
    .instr(instr), .data_page(data_page), .ind_addr(ind_addr),
    .op_hit(op_hit), .op_daddr(op_daddr)
  );

  tblw_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .op_hit(op_hit),
    .rpt_cnt(rpt_cnt), .beat_ok(beat_ok), .load(load),
    .step_addr(step_addr), .restore(restore), .in_xfer(in_xfer),
    .busy(busy), .pc_step(pc_step), .done(done)
  );

  tblw_addr #(.AW(AW), .DAW(DAW), .ROM_WORDS(ROM_WORDS)) u_addr (
    .clk(clk), .rst(rst), .load(load), .step_addr(step_addr),
    .restore(restore), .mp_mode(mp_mode), .acc(acc), .pfc_in(pfc_in),
    .op_daddr(op_daddr), .fetch_q(fetch_q), .daddr_q(daddr_q),
    .rom_hit(rom_hit)
  );

  always_comb begin
    beat_ok     = rom_hit || pm_wr_ready;
    dm_rd_en    = in_xfer;
    dm_rd_addr  = daddr_q;
    pm_wr_valid = in_xfer && !rom_hit;
    pm_wr_addr  = fetch_q;
    pm_wr_data  = dm_rd_data;
    fetch_addr  = fetch_q;
  end

  // R7
  rom_guard_chk: assert property (@(posedge clk) disable iff (rst)
    pm_wr_valid |-> (mp_mode || pm_wr_addr >= AW'(ROM_WORDS)));

  // R6
  stall_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (pm_wr_valid && !pm_wr_ready) |=>
      ($stable(pm_wr_addr) && $stable(dm_rd_addr) && dm_rd_en));

  // R3
  daddr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dm_rd_en && $past(dm_rd_en)) |-> $stable(dm_rd_addr));

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && !pc_step && !pm_wr_valid));
endmodule

// File: tb/tblw_engine_tb.sv
`timescale 1ns/1ps
module tblw_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] acc = '0;
  logic [7:0]  rpt_cnt = '0;
  logic [8:0]  data_page = '0;
  logic [15:0] ind_addr = '0;
  logic [15:0] pfc_in = '0;
  logic        mp_mode = 1'b1;
  logic        pm_wr_ready = 1'b1;
  logic        dm_rd_en, pm_wr_valid, busy, pc_step, done;
  logic [15:0] dm_rd_addr, dm_rd_data, pm_wr_addr, pm_wr_data, fetch_addr;

  int tests = 0;
  int fails = 0;
  int pm[int];

  always #2.5 clk = ~clk;

  function automatic logic [15:0] dmv(input logic [15:0] a);
    if (a == 16'd4101) return 16'd4339;
    return (a * 16'h0097) ^ 16'h3C5A;
  endfunction

  assign dm_rd_data = dmv(dm_rd_addr);

  tblw_engine u_dut (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .acc(acc),
    .rpt_cnt(rpt_cnt), .data_page(data_page), .ind_addr(ind_addr),
    .pfc_in(pfc_in), .mp_mode(mp_mode), .dm_rd_en(dm_rd_en),
    .dm_rd_addr(dm_rd_addr), .dm_rd_data(dm_rd_data),
    .pm_wr_valid(pm_wr_valid), .pm_wr_ready(pm_wr_ready),
    .pm_wr_addr(pm_wr_addr), .pm_wr_data(pm_wr_data),
    .fetch_addr(fetch_addr), .busy(busy), .pc_step(pc_step), .done(done)
  );

  // Behavioural reference: phase 0 idle, 1 moving words, 2 putting back.
  int          m_phase = 0;
  int          m_left = 0;
  logic [15:0] m_fetch = '0, m_hold = '0, m_daddr = '0;
  bit          m_done = 0, m_step = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_done = 0; m_step = 0; m_fetch = '0; m_hold = '0;
      m_daddr = '0;
    end else begin
      m_done = 0; m_step = 0;
      if (m_phase == 0) begin
        if (start && instr[15:8] == 8'h59) begin
          m_hold = pfc_in; m_fetch = acc; m_left = int'(rpt_cnt);
          m_daddr = instr[7] ? ind_addr : {data_page, instr[6:0]};
          m_phase = 1; m_step = 1;
        end
      end else if (m_phase == 1) begin
        if ((!mp_mode && m_fetch < 16'd4096) || pm_wr_ready) begin
          if (m_left == 0) m_phase = 2;
          else begin m_left = m_left - 1; m_fetch = m_fetch + 16'd1; end
        end
      end else begin
        m_fetch = m_hold; m_done = 1; m_phase = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e_x, e_v;
    e_x = (m_phase == 1);
    e_v = e_x && !(!mp_mode && m_fetch < 16'd4096);
    chk(busy == (m_phase != 0), "R1", "busy", 16'(busy), 16'(m_phase != 0));
    chk(pc_step == m_step, "R2", "pc_step", 16'(pc_step), 16'(m_step));
    chk(fetch_addr == m_fetch, "R5", "fetch_addr", fetch_addr, m_fetch);
    chk(dm_rd_en == e_x, "R4", "dm_rd_en", 16'(dm_rd_en), 16'(e_x));
    if (e_x) chk(dm_rd_addr == m_daddr, "R3", "dm_rd_addr", dm_rd_addr, m_daddr);
    chk(pm_wr_valid == e_v, "R7", "pm_wr_valid", 16'(pm_wr_valid), 16'(e_v));
    if (e_v) begin
      chk(pm_wr_addr == m_fetch, "R6", "pm_wr_addr", pm_wr_addr, m_fetch);
      chk(pm_wr_data == dmv(m_daddr), "R4", "pm_wr_data", pm_wr_data, dmv(m_daddr));
    end
    chk(done == m_done, "R8", "done", 16'(done), 16'(m_done));
  endtask

  // Record the write the DUT hands over at the coming edge, then compare.
  task automatic step();
    #1;
    if (pm_wr_valid && pm_wr_ready) pm[int'(pm_wr_addr)] = int'(pm_wr_data);
    @(negedge clk);
    compare();
  endtask

  task automatic run_op(input logic [15:0] i_w, input logic [15:0] a,
                        input logic [7:0] n, input logic [8:0] dp,
                        input logic [15:0] ia, input logic [15:0] pf,
                        input bit mode, input logic [7:0] rdy_pat);
    int cyc;
    bit seen;
    instr = i_w; acc = a; rpt_cnt = n; data_page = dp; ind_addr = ia;
    pfc_in = pf; mp_mode = mode; start = 1'b1; pm_wr_ready = 1'b1;
    step();
    start = 1'b0;
    seen = 0;
    for (cyc = 0; cyc < 2000 && !seen; cyc++) begin
      pm_wr_ready = rdy_pat[cyc % 8];
      step();
      if (done) seen = 1;
    end
    pm_wr_ready = 1'b1;
    chk(seen, "R8", "done reached", 16'(seen), 16'd1);
    if (seen) chk(fetch_addr == pf, "R8", "restored fetch", fetch_addr, pf);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k;
    bit ok;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!busy && !done && !pc_step && !pm_wr_valid && !dm_rd_en && fetch_addr == 0,
        "R9", "reset outputs", {11'd0, busy, done, pc_step, pm_wr_valid, dm_rd_en}, 16'd0);
    rst = 1'b0;
    step();

    // R10: worked example, direct then indirect
    pm.delete();
    run_op(16'h5905, 16'd257, 8'd0, 9'd32, 16'd0, 16'h0123, 1'b1, 8'hFF);
    chk(pm.exists(257) && pm[257] == 4339, "R10", "direct pm[257]",
        pm.exists(257) ? 16'(pm[257]) : 16'hFFFF, 16'd4339);
    chk(acc == 16'd257, "R10", "accumulator", acc, 16'd257);
    pm.delete();
    run_op(16'h5980, 16'd257, 8'd0, 9'd0, 16'd4101, 16'h0456, 1'b1, 8'hFF);
    chk(pm.exists(257) && pm[257] == 4339, "R10", "indirect pm[257]",
        pm.exists(257) ? 16'(pm[257]) : 16'hFFFF, 16'd4339);

    // R5 / R6: block of 6 words with gaps in ready
    pm.delete();
    run_op(16'h5911, 16'h2000, 8'd5, 9'd3, 16'd0, 16'h0A00, 1'b1, 8'b1011_0101);
    chk(pm.size() == 6, "R5", "words written", 16'(pm.size()), 16'd6);
    for (k = 0; k < 6; k++) begin
      ok = pm.exists(16'h2000 + k) && pm[16'h2000 + k] == int'(dmv({9'd3, 7'h11}));
      chk(ok, "R5", "block word", 16'(k), 16'(k));
    end

    // R7: block straddles the ROM boundary in microcomputer mode
    pm.delete();
    run_op(16'h5980, 16'd4094, 8'd3, 9'd0, 16'h0777, 16'h0BBB, 1'b0, 8'b0000_0011);
    chk(!pm.exists(4094) && !pm.exists(4095), "R7", "ROM words untouched",
        16'(pm.size()), 16'd2);
    chk(pm.exists(4096) && pm.exists(4097), "R7", "RAM words written",
        16'(pm.size()), 16'd2);

    // R7: processor mode writes low addresses
    pm.delete();
    run_op(16'h5901, 16'd10, 8'd1, 9'd1, 16'd0, 16'h0CCC, 1'b1, 8'hFF);
    chk(pm.exists(10) && pm.exists(11), "R7", "low writes in processor mode",
        16'(pm.size()), 16'd2);

    // R1: wrong opcode is ignored
    instr = 16'h5A05; start = 1'b1; step(); start = 1'b0; step(); step();
    chk(!busy && !pm_wr_valid && !pc_step, "R1", "bad opcode ignored",
        16'(busy), 16'd0);

    // R1: start while busy is ignored; R2 repeat restart on done cycle
    pm.delete();
    instr = 16'h5902; acc = 16'h3000; rpt_cnt = 8'd3; data_page = 9'd2;
    pfc_in = 16'h0111; mp_mode = 1'b1; start = 1'b1; step();
    acc = 16'h5000; pfc_in = 16'h0999;
    for (k = 0; k < 20; k++) begin
      step();
      if (done) break;
    end
    chk(!pm.exists(16'h5000), "R1", "start while busy ignored",
        16'(pm.exists(16'h5000)), 16'd0);
    chk(pm.size() == 4, "R5", "four words", 16'(pm.size()), 16'd4);
    // start is still high on the done cycle: a new operation begins
    step();
    chk(busy, "R1", "restart after done", 16'(busy), 16'd1);
    start = 1'b0;
    for (k = 0; k < 20; k++) begin
      step();
      if (done) break;
    end
    chk(fetch_addr == 16'h0999, "R8", "second restore", fetch_addr, 16'h0999);

    // R9: reset in the middle of an operation
    instr = 16'h5900; rpt_cnt = 8'd9; start = 1'b1; step(); start = 1'b0;
    step();
    rst = 1'b1; step(); step();
    rst = 1'b0;
    chk(!busy && fetch_addr == 0, "R9", "reset mid-operation", fetch_addr, 16'd0);
    step();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule